// File: doc/BRIEF.md
# Accumulator Logic and Rotate Unit

This unit holds the 8-bit accumulator and the carry flag of a small 8-bit controller datapath and applies the single-operand and bitwise operations to them. On each clock edge with the load enable high, it applies the operation chosen by a 4-bit select to the current accumulator, the current carry and an operand that has already been fetched. It writes the result back. When the load enable is low, the state is held.

The operations are bitwise AND, OR and XOR with the operand, clear, complement, increment, decrement, four rotates and a nibble swap. Two of the rotates go through the carry flag. The other two are plain circular rotates. A zero flag is derived continuously from the stored accumulator. Addition and subtraction with flag generation are handled elsewhere.

Top module: `acc_logic_unit`

## Requirements
- R1: Reset (active-low `rst_n`) clears the accumulator and the carry to zero. While `ld_en` is low, neither changes on a clock edge.
- R2: Select codes 0, 1 and 2 load the accumulator with acc AND operand, acc OR operand and acc XOR operand. Carry is unchanged.
- R3: Code 3 loads zero and code 4 loads the bitwise inverse of the accumulator. Carry is unchanged.
- R4: Code 5 adds one and code 6 subtracts one, both modulo 256 (0xFF+1 gives 0x00 and 0x00-1 gives 0xFF). Carry is unchanged.
- R5: Code 7 rotates left (bit 7 goes to bit 0) and code 8 rotates right (bit 0 goes to bit 7). Carry is unchanged.
- R6: Code 9 rotates left through the carry: the new carry is old bit 7 and the new bit 0 is the old carry.
- R7: Code 10 rotates right through the carry: the new carry is old bit 0 and the new bit 7 is the old carry.
- R8: Code 11 exchanges bits 7:4 with bits 3:0. Carry is unchanged.
- R9: `zero` is high exactly when the stored accumulator equals 0x00.
- R10: Codes 12 to 15 leave both the accumulator and the carry unchanged even when `ld_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Apply the selected operation on this edge |
| op_sel | input | 4 | Operation code |
| operand | input | 8 | Pre-fetched operand byte |
| acc | output | 8 | Stored accumulator |
| carry | output | 1 | Stored carry flag |
| zero | output | 1 | High when acc is 0x00 |

## Verification
The hardest state to reach is a through-carry rotate whose incoming carry is 1. Only the two through-carry rotates can set the carry. The bench therefore first steers bit 7 or bit 0 to 1, rotates it into the carry, and then applies the opposite rotate so the set carry re-enters the byte. Random sequences of operations keep the carry history mixed. Directed runs also cover the wrap points of increment and decrement and a zero result.

// File: rtl/acc_logic_unit.sv
module acc_logic_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic         carry,
  output logic         zero
);
  localparam int H = W / 2;

  logic [W-1:0] nxt_acc;
  logic         nxt_c;

  always_comb begin
    nxt_acc = acc;
    nxt_c   = carry;
    case (op_sel)
      4'd0:  nxt_acc = acc & operand;
      4'd1:  nxt_acc = acc | operand;
      4'd2:  nxt_acc = acc ^ operand;
      4'd3:  nxt_acc = '0;
      4'd4:  nxt_acc = ~acc;
      4'd5:  nxt_acc = acc + 1'b1;
      4'd6:  nxt_acc = acc - 1'b1;
      4'd7:  nxt_acc = {acc[W-2:0], acc[W-1]};
      4'd8:  nxt_acc = {acc[0], acc[W-1:1]};
      4'd9:  begin nxt_acc = {acc[W-2:0], carry}; nxt_c = acc[W-1]; end
      4'd10: begin nxt_acc = {carry, acc[W-1:1]}; nxt_c = acc[0]; end
      4'd11: nxt_acc = {acc[H-1:0], acc[W-1:H]};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      carry <= 1'b0;
    end else if (ld_en) begin
      acc   <= nxt_acc;
      carry <= nxt_c;
    end
  end

  assign zero = (acc == '0);
endmodule

module acc_logic_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_en,
  input logic [3:0]   op_sel,
  input logic [W-1:0] acc,
  input logic         carry,
  input logic         zero
);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ($stable(acc) && $stable(carry)));
  a_r6_rlc_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel == 4'd9) |=> (carry == $past(acc[W-1]) && acc[0] == $past(carry)));
  a_r7_rrc_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel == 4'd10) |=> (carry == $past(acc[0]) && acc[W-1] == $past(carry)));
  a_r4_inc_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && (op_sel == 4'd5 || op_sel == 4'd6)) |=> $stable(carry));
  a_r5_rot_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && (op_sel == 4'd7 || op_sel == 4'd8 || op_sel == 4'd11)) |=> $stable(carry));
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel >= 4'd12) |=> ($stable(acc) && $stable(carry)));
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel == 4'd3) |=> zero);
  always_comb if (rst_n) a_r9_zero: assert (zero == (acc == '0));
endmodule

bind acc_logic_unit acc_logic_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .op_sel(op_sel),
  .acc(acc), .carry(carry), .zero(zero));

// File: tb/tb_acc_logic_unit.sv
module tb_acc_logic_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, ld_en = 0;
  logic [3:0] op_sel = 0;
  logic [7:0] operand = 0;
  logic [7:0] acc;
  logic carry, zero;

  int total = 0, bad = 0;
  logic [7:0] m_acc = 0;
  logic m_c = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_logic_unit dut (.clk(clk), .rst_n(rst_n), .ld_en(ld_en), .op_sel(op_sel),
    .operand(operand), .acc(acc), .carry(carry), .zero(zero));

  function automatic logic [8:0] model(input logic [3:0] op, input logic [7:0] a,
                                       input logic c, input logic [7:0] d);
    case (op)
      0: return {c, a & d};
      1: return {c, a | d};
      2: return {c, a ^ d};
      3: return {c, 8'h00};
      4: return {c, ~a};
      5: return {c, 8'(a + 8'd1)};
      6: return {c, 8'(a - 8'd1)};
      7: return {c, a[6:0], a[7]};
      8: return {c, a[0], a[7:1]};
      9: return {a[7], a[6:0], c};
      10: return {a[0], c, a[7:1]};
      11: return {c, a[3:0], a[7:4]};
      default: return {c, a};
    endcase
  endfunction

  function automatic string rname(input logic [3:0] op);
    case (op)
      0,1,2: return "R2";
      3,4: return "R3";
      5,6: return "R4";
      7,8: return "R5";
      9: return "R6";
      10: return "R7";
      11: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] ea, input logic ec);
    total++;
    if (acc !== ea || carry !== ec || zero !== (ea == 0)) begin
      bad++;
      $display("FAIL %s acc=%h c=%b z=%b expected acc=%h c=%b z=%b",
               req, acc, carry, zero, ea, ec, (ea == 0));
    end
  endtask

  task automatic step(input logic en, input logic [3:0] op, input logic [7:0] d);
    logic [8:0] r;
    ld_en = en; op_sel = op; operand = d;
    @(posedge clk);
    if (en) begin r = model(op, m_acc, m_c, d); m_c = r[8]; m_acc = r[7:0]; end
    #(CLK_PERIOD/4);
    check(en ? rname(op) : "R1", m_acc, m_c);
    if (zero !== (acc == 0)) begin total++; end
  endtask

  task automatic load(input logic [7:0] v);
    step(1, 3, 0); step(1, 1, v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog acc=%h expected completion", acc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2);
    check("R1", 8'h00, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // R9 zero after reset
    check("R9", 8'h00, 1'b0);
    // R6/R7 carry in with set carry
    load(8'h80); step(1, 9, 0);   // carry=1, acc=00
    check("R6", 8'h00, 1'b1);
    step(1, 10, 0);               // acc=80, c=0
    load(8'h01); step(1, 10, 0);  // c=1, acc=00
    step(1, 9, 0);                // acc=01, c=0
    step(1, 10, 0); step(1, 10, 0); // c=1 then acc=80 c=0
    load(8'h81); step(1, 9, 0); step(1, 10, 0);
    // R4 wrap edges
    load(8'hFF); step(1, 5, 0);
    step(1, 6, 0);
    // R8 swap
    load(8'hA5); step(1, 11, 0);
    // R5 plain rotates
    step(1, 7, 0); step(1, 8, 0);
    // R3
    step(1, 4, 0); step(1, 3, 0);
    // R1 hold and R10 reserved
    load(8'h3C); step(0, 4, 8'hFF); step(0, 3, 0);
    for (int k = 12; k < 16; k++) step(1, 4'(k), 8'hFF);
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++)
      step(($urandom % 8) != 0, 4'($urandom % 16), 8'($urandom));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule